// File: doc/BRIEF.md
# Standby/Run Power Mode Controller

This block sequences a two-mode power controller for a host processor that can be switched off. In standby the regulator enable is low and the block waits for a wake event. A wake event starts a reset pulse, raises the regulator enable and moves the block to run mode. In run mode the host is supervised in two ways: it must keep its watchdog alive, and it must collect its status reads. A failed watchdog trigger or a missed status read counts as a strike and restarts the host with a fresh reset pulse. The fifth strike in a row removes the regulator enable and returns the block to standby.

All timing comes from a 32.768 kHz tick enable, one clock wide. The reset pulse width is chosen by a two-bit field of the control word. The first cycle of every reset pulse also gives a one-cycle clear to the bus interface logic. From that first cycle on, the external wake inputs are locked out until the host sends an enable-reset command. The control word lets the host ask for standby and drive the regulator enable directly while it runs.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After the asynchronous reset, `run_o`, `onoff_o`, `rst_pulse_o`, `bus_rst_o` and `in_lock_o` are all 0, and the width select is 2'b11.
- R2: In standby, a supply event or an oscillator fault sets `run_o`, `onoff_o` and `rst_pulse_o` at the next clock edge, whatever the lockout state is.
- R3: In standby, an alarm, input-change or impedance event wakes the block in the same way as R2 only while `in_lock_o` is 0. While it is 1, these events change nothing.
- R4: In run mode, a watchdog failure or missed read (when it is not the fifth strike), an oscillator fault, or `host_rst_n_i` low starts a reset pulse and forces `onoff_o` to 1. Alarm, input-change and impedance events in run mode have no effect.
- R5: Width select `ctrl_i[3:2]` gives the reset pulse length in ticks: 00 gives 33, 01 gives 164, 10 gives 328 and 11 gives 655. It is written on every control write, in either mode.
- R6: A trigger that arrives while the pulse is high restarts the full count, without a low gap in the pulse.
- R7: When the pulse rises, `in_lock_o` goes to 1 and `bus_rst_o` is high for exactly that first cycle. An `en_reset_i` pulse clears `in_lock_o`.
- R8: On the fifth consecutive strike in run mode (`wd_fail_i` or `rd_miss_i`), `onoff_o` and `run_o` go to 0 and no new pulse starts.
- R9: A `wd_ok_i` or `rd_ok_i` pulse clears the strike count.
- R10: In run mode, a control write with `ctrl_i[0]`=1 enters standby with `onoff_o`=0. Otherwise the write sets `onoff_o` to `ctrl_i[1]`.
- R11: In standby, watchdog failures, missed reads, a low `host_rst_n_i` and `ctrl_i[1]` have no effect on the mode, the pulse or `onoff_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 32.768 kHz tick enable, one cycle wide |
| supply_evt_i | input | 1 | Device supply reset event |
| osc_fault_i | input | 1 | Oscillator fault |
| alarm_evt_i | input | 1 | Alarm pulse from the watch counter |
| din_change_i | input | 1 | Change seen on the monitored inputs |
| imped_evt_i | input | 1 | Impedance detection |
| host_rst_n_i | input | 1 | Host reset request, active low |
| wd_fail_i | input | 1 | Failed watchdog trigger |
| wd_ok_i | input | 1 | Successful watchdog trigger |
| rd_miss_i | input | 1 | Missed status read |
| rd_ok_i | input | 1 | Completed status read |
| ctrl_wr_i | input | 1 | Control word write strobe |
| ctrl_i | input | 4 | Control word: [0] standby request, [1] enable value, [3:2] width select |
| en_reset_i | input | 1 | Enable-reset command |
| onoff_o | output | 1 | Regulator enable |
| rst_pulse_o | output | 1 | Reset pulse to the host |
| bus_rst_o | output | 1 | One-cycle clear for the bus interface |
| in_lock_o | output | 1 | Wake-input lockout flag |
| run_o | output | 1 | 1 in run mode, 0 in standby |

## Verification
The bench restarts a pulse that is already running and expects the tick count to begin again from the full width. A design that ignored the retrigger would end the pulse too early. A design that let it through as a new rise would give a second bus clear. The bench also sends four strikes, then a success, then four more strikes, and checks that standby comes only after five failures in a row. A counter that does not clear would drop the regulator on the fifth failure overall. The other corner cases are locked-out wake events, supervision events during standby, and random width settings, each measured in ticks. Each of these catches a design that gates the wrong inputs or loads the wrong count.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic {
    MODE_STBY = 1'b0,
    MODE_RUN  = 1'b1
  } mode_e;

  // control word layout: {width_sel[1:0], onoff_set, stby_req}
  typedef struct packed {
    logic [1:0] width_sel;
    logic       onoff_set;
    logic       stby_req;
  } ctrl_t;

endpackage

// File: rtl/pmc_pulse_timer.sv
module pmc_pulse_timer #(
  parameter int W0 = 33,
  parameter int W1 = 164,
  parameter int W2 = 328,
  parameter int W3 = 655
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic [1:0] sel_i,
  output logic       pulse_o,
  output logic       rise_o
);

  localparam int WMAX01 = (W0 > W1) ? W0 : W1;
  localparam int WMAX23 = (W2 > W3) ? W2 : W3;
  localparam int WMAX   = (WMAX01 > WMAX23) ? WMAX01 : WMAX23;
  localparam int CW     = $clog2(WMAX + 1);

  logic [CW-1:0] cnt_q, cnt_d, load_val;
  logic          act_q, act_d;
  logic          rise_q, rise_d;

  always_comb begin
    case (sel_i)
      2'd0:    load_val = CW'(W0);
      2'd1:    load_val = CW'(W1);
      2'd2:    load_val = CW'(W2);
      default: load_val = CW'(W3);
    endcase
  end

  always_comb begin
    cnt_d  = cnt_q;
    act_d  = act_q;
    rise_d = 1'b0;
    if (start_i) begin
      cnt_d  = load_val;
      act_d  = 1'b1;
      rise_d = ~act_q;
    end else if (act_q && tick_i) begin
      if (cnt_q == CW'(1)) begin
        act_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      act_q  <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      rise_q <= rise_d;
    end
  end

  assign pulse_o = act_q;
  assign rise_o  = rise_q;

  // R5: the pulse only ends on a tick
  a_r5_ends_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> $past(tick_i));

  // R6: an active pulse always has ticks left
  a_r6_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cnt_q != '0));

  // R7: the bus clear marks only the first high cycle
  a_r7_rise_first_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |-> (act_q && !$past(act_q)));

endmodule

// File: rtl/pmc_strike_ctr.sv
module pmc_strike_ctr #(
  parameter int STRIKES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic fail_i,
  input  logic ok_i,
  output logic last_o
);

  localparam int SW = $clog2(STRIKES + 1);

  logic [SW-1:0] cnt_q, cnt_d;
  logic          at_limit;

  assign at_limit = (cnt_q == SW'(STRIKES - 1));
  assign last_o   = arm_i & fail_i & ~ok_i & at_limit;

  always_comb begin
    cnt_d = cnt_q;
    if (!arm_i || ok_i) begin
      cnt_d = '0;
    end else if (fail_i) begin
      cnt_d = at_limit ? '0 : cnt_q + SW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R8: count never reaches the strike limit
  a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < SW'(STRIKES));

  // R9: a success leaves the count at zero
  a_r9_ok_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ok_i) |-> (cnt_q == '0));

  // R11: supervision is idle outside run mode
  a_r11_idle_standby: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(arm_i) |-> (cnt_q == '0));

endmodule

// File: rtl/pmc_mode_seq.sv
module pmc_mode_seq
  import pmc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic supply_i,
  input  logic osc_i,
  input  logic ext_wake_i,
  input  logic lock_i,
  input  logic run_fail_i,
  input  logic host_rst_n_i,
  input  logic last_strike_i,
  input  logic ctrl_wr_i,
  input  logic stby_req_i,
  input  logic onoff_set_i,
  output logic run_o,
  output logic onoff_o,
  output logic start_o
);

  mode_e mode_q, mode_d;
  logic  onoff_q, onoff_d;
  logic  wake;
  logic  run_trig;

  assign wake     = supply_i | osc_i | (ext_wake_i & ~lock_i);
  assign run_trig = run_fail_i | osc_i | ~host_rst_n_i;

  always_comb begin
    mode_d  = mode_q;
    onoff_d = onoff_q;
    start_o = 1'b0;
    if (mode_q == MODE_STBY) begin
      if (wake) begin
        mode_d  = MODE_RUN;
        onoff_d = 1'b1;
        start_o = 1'b1;
      end
    end else if (last_strike_i) begin
      mode_d  = MODE_STBY;
      onoff_d = 1'b0;
    end else if (run_trig) begin
      onoff_d = 1'b1;
      start_o = 1'b1;
    end else if (ctrl_wr_i) begin
      if (stby_req_i) begin
        mode_d  = MODE_STBY;
        onoff_d = 1'b0;
      end else begin
        onoff_d = onoff_set_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_STBY;
      onoff_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      onoff_q <= onoff_d;
    end
  end

  assign run_o   = (mode_q == MODE_RUN);
  assign onoff_o = onoff_q;

  // R8 / R10: regulator is off whenever the block is in standby
  a_r8_off_in_standby: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_STBY) |-> !onoff_q);

  // R2: entering run always raises the enable
  a_r2_wake_enables: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q == MODE_STBY) && (mode_q == MODE_RUN)) |-> onoff_q);

  // R4: a run-mode trigger leaves the enable high
  a_r4_trigger_enables: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q == MODE_RUN) && $past(start_o)) |-> onoff_q);

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int W0      = 33,
  parameter int W1      = 164,
  parameter int W2      = 328,
  parameter int W3      = 655,
  parameter int STRIKES = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       supply_evt_i,
  input  logic       osc_fault_i,
  input  logic       alarm_evt_i,
  input  logic       din_change_i,
  input  logic       imped_evt_i,
  input  logic       host_rst_n_i,
  input  logic       wd_fail_i,
  input  logic       wd_ok_i,
  input  logic       rd_miss_i,
  input  logic       rd_ok_i,
  input  logic       ctrl_wr_i,
  input  logic [3:0] ctrl_i,
  input  logic       en_reset_i,
  output logic       onoff_o,
  output logic       rst_pulse_o,
  output logic       bus_rst_o,
  output logic       in_lock_o,
  output logic       run_o
);

  ctrl_t      ctrl;
  logic [1:0] sel_q, sel_d;
  logic       lock_q, lock_d;
  logic       start;
  logic       last_strike;
  logic       pulse;
  logic       rise;
  logic       run;

  assign ctrl = ctrl_t'(ctrl_i);

  always_comb begin
    sel_d = sel_q;
    if (ctrl_wr_i) sel_d = ctrl.width_sel;
  end

  always_comb begin
    lock_d = lock_q;
    if (start && !pulse) lock_d = 1'b1;
    else if (en_reset_i) lock_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 2'b11;
      lock_q <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      lock_q <= lock_d;
    end
  end

  pmc_mode_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .supply_i      (supply_evt_i),
    .osc_i         (osc_fault_i),
    .ext_wake_i    (alarm_evt_i | din_change_i | imped_evt_i),
    .lock_i        (lock_q),
    .run_fail_i    (wd_fail_i | rd_miss_i),
    .host_rst_n_i  (host_rst_n_i),
    .last_strike_i (last_strike),
    .ctrl_wr_i     (ctrl_wr_i),
    .stby_req_i    (ctrl.stby_req),
    .onoff_set_i   (ctrl.onoff_set),
    .run_o         (run),
    .onoff_o       (onoff_o),
    .start_o       (start)
  );

  pmc_strike_ctr #(.STRIKES(STRIKES)) u_strike (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm_i  (run),
    .fail_i (wd_fail_i | rd_miss_i),
    .ok_i   (wd_ok_i | rd_ok_i),
    .last_o (last_strike)
  );

  pmc_pulse_timer #(.W0(W0), .W1(W1), .W2(W2), .W3(W3)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .start_i (start),
    .sel_i   (sel_q),
    .pulse_o (pulse),
    .rise_o  (rise)
  );

  assign rst_pulse_o = pulse;
  assign bus_rst_o   = rise;
  assign in_lock_o   = lock_q;
  assign run_o       = run;

  // R7: lockout is set no later than the pulse rise
  a_r7_lock_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> lock_q);

  // R8: the fifth strike never starts a pulse
  a_r8_no_pulse_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !run) |-> !rise);

endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick = 1'b0;
  logic       tick_run;
  logic       supply_evt, osc_fault, alarm_evt, din_change, imped_evt;
  logic       host_rst_n, wd_fail, wd_ok, rd_miss, rd_ok;
  logic       ctrl_wr;
  logic [3:0] ctrl;
  logic       en_reset;
  logic       onoff, rst_pulse, bus_rst, in_lock, run;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  always @(posedge clk) tick <= tick_run ? ~tick : 1'b0;

  pwr_mode_ctrl u_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .supply_evt_i(supply_evt), .osc_fault_i(osc_fault), .alarm_evt_i(alarm_evt),
    .din_change_i(din_change), .imped_evt_i(imped_evt), .host_rst_n_i(host_rst_n),
    .wd_fail_i(wd_fail), .wd_ok_i(wd_ok), .rd_miss_i(rd_miss), .rd_ok_i(rd_ok),
    .ctrl_wr_i(ctrl_wr), .ctrl_i(ctrl), .en_reset_i(en_reset),
    .onoff_o(onoff), .rst_pulse_o(rst_pulse), .bus_rst_o(bus_rst),
    .in_lock_o(in_lock), .run_o(run)
  );

  function automatic int exp_width(input int sel);
    case (sel)
      0:       return 33;
      1:       return 164;
      2:       return 328;
      default: return 655;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // 0 supply,1 osc,2 alarm,3 din,4 imped,5 host rst,6 wd_fail,7 rd_miss,
  // 8 wd_ok,9 rd_ok,10 en_reset
  task automatic fire(input int which);
    while (tick) step();
    case (which)
      0: supply_evt = 1'b1;
      1: osc_fault  = 1'b1;
      2: alarm_evt  = 1'b1;
      3: din_change = 1'b1;
      4: imped_evt  = 1'b1;
      5: host_rst_n = 1'b0;
      6: wd_fail    = 1'b1;
      7: rd_miss    = 1'b1;
      8: wd_ok      = 1'b1;
      9: rd_ok      = 1'b1;
      default: en_reset = 1'b1;
    endcase
    step();
    supply_evt = 0; osc_fault = 0; alarm_evt = 0; din_change = 0; imped_evt = 0;
    host_rst_n = 1; wd_fail = 0; rd_miss = 0; wd_ok = 0; rd_ok = 0; en_reset = 0;
  endtask

  task automatic wr_ctrl(input logic [3:0] v);
    while (tick) step();
    ctrl = v; ctrl_wr = 1'b1;
    step();
    ctrl_wr = 1'b0;
  endtask

  task automatic measure(output int n);
    n = 0;
    for (int g = 0; g < 5000 && rst_pulse; g++) begin
      if (tick) n++;
      step();
    end
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 5000 && rst_pulse; g++) step();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int n, cnt, sel, src;
    void'($urandom(32'd4242));
    rst_n = 0; tick_run = 0;
    supply_evt = 0; osc_fault = 0; alarm_evt = 0; din_change = 0; imped_evt = 0;
    host_rst_n = 1; wd_fail = 0; rd_miss = 0; wd_ok = 0; rd_ok = 0; en_reset = 0;
    ctrl_wr = 0; ctrl = '0;
    repeat (3) step();
    rst_n = 1;
    step();
    tick_run = 1;
    // R1 reset state
    chk("R1 run", run, 0);       chk("R1 onoff", onoff, 0);
    chk("R1 pulse", rst_pulse, 0); chk("R1 bus_rst", bus_rst, 0);
    chk("R1 lock", in_lock, 0);

    // R11 supervision ignored in standby
    fire(6); fire(7); fire(5);
    chk("R11 run", run, 0); chk("R11 pulse", rst_pulse, 0);
    wr_ctrl(4'b1110);
    chk("R11 onoff", onoff, 0); chk("R11 run after ctrl", run, 0);

    // R2 wake by supply, default width
    fire(0);
    chk("R2 run", run, 1); chk("R2 onoff", onoff, 1); chk("R2 pulse", rst_pulse, 1);
    chk("R7 bus_rst first", bus_rst, 1); chk("R7 lock set", in_lock, 1);
    step();
    chk("R7 bus_rst one cycle", bus_rst, 0);
    measure(n);
    chk("R5 default width 11", n + 1, exp_width(3));

    // R10 standby request, sel 00
    wr_ctrl(4'b0001);
    chk("R10 standby run", run, 0); chk("R10 standby onoff", onoff, 0);
    // R3 locked wakes ignored
    fire(2); fire(3); fire(4);
    chk("R3 locked run", run, 0); chk("R3 locked pulse", rst_pulse, 0);
    fire(10);
    chk("R7 lock cleared", in_lock, 0);
    fire(3);
    chk("R3 unlocked run", run, 1); chk("R3 unlocked pulse", rst_pulse, 1);
    measure(n);
    chk("R5 width 00", n, exp_width(0));

    // R10 onoff control in run
    wr_ctrl(4'b0000);
    chk("R10 onoff low", onoff, 0); chk("R10 still run", run, 1);
    wr_ctrl(4'b0010);
    chk("R10 onoff high", onoff, 1);

    // R4 run triggers
    wr_ctrl(4'b0000);
    fire(1);
    chk("R4 osc onoff", onoff, 1); chk("R4 osc pulse", rst_pulse, 1);
    wait_idle();
    wr_ctrl(4'b0000);
    fire(5);
    chk("R4 host onoff", onoff, 1); chk("R4 host pulse", rst_pulse, 1);
    wait_idle();
    fire(2); fire(4);
    chk("R4 alarm ignored pulse", rst_pulse, 0); chk("R4 alarm run", run, 1);

    // R6 retrigger restarts full count
    fire(1);
    cnt = 0;
    while (cnt < 10) begin if (tick) cnt++; step(); end
    fire(1);
    chk("R6 no new rise", bus_rst, 0);
    measure(n);
    chk("R6 retrigger total", cnt + n, 10 + exp_width(0));

    // R9 / R8 strike counting
    wait_idle();
    for (int i = 0; i < 4; i++) begin fire(6); chk("R9 wd strike run", run, 1); end
    fire(8);
    for (int i = 0; i < 4; i++) begin fire(7); chk("R9 rd strike run", run, 1); end
    fire(7);
    chk("R8 drop run", run, 0); chk("R8 drop onoff", onoff, 0);
    chk("R8 no new rise", bus_rst, 0);

    // random widths and wake sources
    for (int it = 0; it < 6; it++) begin
      wait_idle();
      fire(10);
      sel = int'($urandom % 4);
      src = int'($urandom % 5);
      wr_ctrl({sel[1:0], 2'b00});
      fire(src);
      chk("R2 random wake run", run, 1);
      measure(n);
      chk("R5 random width", n, exp_width(sel));
      wr_ctrl({sel[1:0], 2'b01});
      chk("R10 random standby", run, 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

endmodule